// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block gathers a set of active-high, level-sensitive interrupt request lines into a single request toward a parent interrupt controller. Each source carries its own enable bit. The combined request is high while at least one enabled source is asserted. Nothing is latched, so a source stops counting as pending as soon as its line drops. No acknowledge step exists.

A host reaches the block over a simple 32-bit register bus with byte offsets. It can read the enabled-and-asserted view, the raw input levels and the enable vector. It changes enables only through two write-one strobe registers, one that turns enables on and one that turns them off, so no read-modify-write is ever needed. A helper register gives the number of the lowest pending source, because the lowest number is serviced first.

Register offsets:

| Offset | Access | Content |
|---|---|---|
| 0x00 | read | pending view (level AND enable) |
| 0x04 | read | raw synchronized levels |
| 0x08 | read, write-one-to-set | enable vector |
| 0x0C | read, write-one-to-clear | enable vector |
| 0x10 | read | lowest pending index |

Top module: `lvl_irq_agg`

## Requirements
- R1: After reset every enable bit is 0, the pending view at 0x00 reads 0 and `irq_out` is low.
- R2: Offset 0x04 returns the level of every source after a two-flop synchronizer, regardless of its enable bit.
- R3: Offset 0x00 returns bit i as 1 exactly when source i is asserted and enable bit i is 1.
- R4: A write to 0x08 sets each enable bit whose data bit is 1. Bits written as 0 keep their value.
- R5: A write to 0x0C clears each enable bit whose data bit is 1. Bits written as 0 keep their value.
- R6: Reads of 0x08 and of 0x0C both return the current enable vector.
- R7: Writes to 0x00, 0x04 and 0x10 change no enable bit and no readable state.
- R8: `irq_out` is registered and is high exactly when any pending bit was 1 in the previous cycle. It follows a source change after 3 clocks and an enable write after 1 clock.
- R9: Offset 0x10 returns the lowest-numbered pending source index in bits 4:0 and a valid flag in bit 31. The whole word reads 0 when nothing is pending.
- R10: Pending state follows the input level. When a source drops, its bit and `irq_out` return to 0 without any host access.
- R11: Read data appears on `rd_data` in the cycle after `rd_en` is sampled. An unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| src_irq | input | 32 | asynchronous level request lines |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | 5 | byte offset |
| wr_data | input | 32 | write data |
| rd_data | output | 32 | registered read data |
| irq_out | output | 1 | combined request to the parent controller |

## Verification
The bench uses several source patterns. A single low source and a single high source show whether bit order is kept. A mix of enabled and disabled sources separates the raw view from the pending view. Scattered set and clear masks show whether unwritten enable bits are left alone. Patterns with both bit 31 and a middle bit pending, or with bit 31 alone, check that the lowest index wins. The bench also counts the clocks from a source edge and from an enable write to `irq_out`, which exposes any missing or extra register stage.

// File: rtl/lia_pkg.sv
package lia_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFF_PEND = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_RAW  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_ENSET = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_ENCLR = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_FIRST = 5'h10;
endpackage

// File: rtl/lia_sync.sv
module lia_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_async;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/lia_enable_reg.sv
module lia_enable_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (set_we) en_q <= en_q | wdata;
    else if (clr_we) en_q <= en_q & ~wdata;
  end

  assert_set_bits_R4: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((en_q & $past(wdata)) == $past(wdata)));
  assert_set_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));
  assert_clr_bits_R5: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((en_q & $past(wdata)) == '0));
  assert_clr_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));
  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(en_q));
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_q == '0));
endmodule

// File: rtl/lia_first_pending.sv
module lia_first_pending #(
  parameter int WIDTH = 32,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pend,
  output logic [IDX_W-1:0] idx,
  output logic             valid
);
  always_comb begin
    idx = '0;
    for (int i = WIDTH-1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
    valid = |pend;
  end

  assert_idx_pending_R9: assert property (@(posedge clk) disable iff (rst)
    valid |-> pend[idx]);
  assert_idx_lowest_R9: assert property (@(posedge clk) disable iff (rst)
    valid |-> ((pend & ((WIDTH'(1) << idx) - WIDTH'(1))) == '0));
endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg
  import lia_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_out
);
  logic [NUM_SRC-1:0] raw_lvl;
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] pend_vec;
  logic [IDX_W-1:0]   first_idx;
  logic               first_vld;
  logic               set_we;
  logic               clr_we;
  logic [DATA_W-1:0]  rd_mux;

  lia_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(src_irq), .q_sync(raw_lvl));

  assign set_we = wr_en && (addr == OFF_ENSET);
  assign clr_we = wr_en && (addr == OFF_ENCLR);

  lia_enable_reg #(.WIDTH(NUM_SRC)) u_en (
    .clk(clk), .rst(rst), .set_we(set_we), .clr_we(clr_we),
    .wdata(wr_data[NUM_SRC-1:0]), .en_q(en_vec));

  assign pend_vec = raw_lvl & en_vec;

  lia_first_pending #(.WIDTH(NUM_SRC)) u_first (
    .clk(clk), .rst(rst), .pend(pend_vec), .idx(first_idx), .valid(first_vld));

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFF_PEND:  rd_mux[NUM_SRC-1:0] = pend_vec;
      OFF_RAW:   rd_mux[NUM_SRC-1:0] = raw_lvl;
      OFF_ENSET,
      OFF_ENCLR: rd_mux[NUM_SRC-1:0] = en_vec;
      OFF_FIRST: begin
        rd_mux[DATA_W-1]  = first_vld;
        rd_mux[IDX_W-1:0] = first_idx;
      end
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_out <= 1'b0;
    end else begin
      rd_data <= rd_en ? rd_mux : '0;
      irq_out <= |pend_vec;
    end
  end

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (rst)
    irq_out == $past(|(raw_lvl & en_vec)));
  assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(en_vec) != '0));
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_out && rd_data == '0));
endmodule

// File: tb/lvl_irq_agg_bench.sv
`timescale 1ns/1ps
module lvl_irq_agg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_irq = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_out;

  int checks = 0;
  int failures = 0;
  logic [31:0] m_en = '0;

  always #2 clk = ~clk;

  lvl_irq_agg u_lvl_irq_agg (
    .clk(clk), .rst(rst), .src_irq(src_irq), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    if (a == 5'h08) m_en = m_en | d;
    if (a == 5'h0C) m_en = m_en & ~d;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk);
    src_irq = v;
    cyc(4);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(5'h08, d); check("R1 enable after reset", d, 32'h0);
    bus_rd(5'h00, d); check("R1 pending after reset", d, 32'h0);
    check("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_raw_and_mask();
    logic [31:0] d;
    set_src(32'hA5A5_0F01);
    bus_rd(5'h04, d); check("R2 raw with no enables", d, 32'hA5A5_0F01);
    bus_rd(5'h00, d); check("R3 pending with no enables", d, 32'h0);
    check("R3 irq_out low when all disabled", {31'b0, irq_out}, 32'h0);
    bus_wr(5'h08, 32'h0000_FF00);
    bus_rd(5'h00, d); check("R3 pending partial mask", d, 32'hA5A5_0F01 & m_en);
    bus_rd(5'h04, d); check("R2 raw independent of enables", d, 32'hA5A5_0F01);
    check("R8 irq_out with pending", {31'b0, irq_out}, 32'h1);
  endtask

  task automatic t_set_clear();
    logic [31:0] d;
    bus_wr(5'h08, 32'h8000_0001);
    bus_rd(5'h08, d); check("R4 set keeps others", d, m_en);
    check("R4 model value", m_en, 32'h8000_FF01);
    bus_wr(5'h0C, 32'h0000_0F01);
    bus_rd(5'h0C, d); check("R5 clear keeps others", d, 32'h8000_F000);
    bus_rd(5'h08, d); check("R6 both offsets agree", d, m_en);
    bus_wr(5'h0C, 32'h0);
    bus_rd(5'h0C, d); check("R5 zero clear no change", d, 32'h8000_F000);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    bus_wr(5'h00, 32'hFFFF_FFFF);
    bus_wr(5'h04, 32'hFFFF_FFFF);
    bus_wr(5'h10, 32'hFFFF_FFFF);
    bus_rd(5'h08, d); check("R7 read-only writes ignored", d, 32'h8000_F000);
    bus_rd(5'h04, d); check("R7 raw unchanged by write", d, src_irq);
    bus_rd(5'h14, d); check("R11 unmapped reads zero", d, 32'h0);
    @(negedge clk); addr = 5'h04;
    cyc(1); check("R11 no read strobe gives zero", rd_data, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    bus_wr(5'h08, 32'hFFFF_FFFF);
    set_src(32'h8000_0010);
    bus_rd(5'h10, d); check("R9 lowest of two", d, 32'h8000_0004);
    set_src(32'h8000_0000);
    bus_rd(5'h10, d); check("R9 bit 31 alone", d, 32'h8000_001F);
    set_src(32'h0000_0001);
    bus_rd(5'h10, d); check("R9 bit 0", d, 32'h8000_0000);
    set_src(32'h0);
    bus_rd(5'h10, d); check("R9 none pending", d, 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    @(negedge clk); src_irq = 32'h0000_0040;
    cyc(2); check("R8 irq low after 2 clocks", {31'b0, irq_out}, 32'h0);
    cyc(1); check("R8 irq high after 3 clocks", {31'b0, irq_out}, 32'h1);
    @(negedge clk); src_irq = 32'h0;
    cyc(2); check("R10 irq still high after 2", {31'b0, irq_out}, 32'h1);
    cyc(1); check("R10 irq drops with level", {31'b0, irq_out}, 32'h0);
    bus_rd(5'h00, d); check("R10 pending clears without ack", d, 32'h0);
    set_src(32'h0000_0100);
    bus_wr(5'h0C, 32'h0000_0100);
    check("R8 irq one clock after disable", {31'b0, irq_out}, 32'h1);
    cyc(1); check("R8 irq low after disable", {31'b0, irq_out}, 32'h0);
    bus_wr(5'h08, 32'h0000_0100);
    check("R8 irq before enable takes effect", {31'b0, irq_out}, 32'h0);
    cyc(1); check("R8 irq after enable", {31'b0, irq_out}, 32'h1);
  endtask

  initial begin
    cyc(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_raw_and_mask();
    t_set_clear();
    t_ignored();
    t_priority();
    t_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule